// File: doc/BRIEF.md
# Free-Running Match Timer

This block is a memory-mapped system timer. It holds a free-running up-counter that advances on a slow tick strobe. Up to four compare registers are matched against it, and each hit sets a sticky flag that can raise a level interrupt. The tick belongs to a slower counter domain. That domain is modelled here as a one-cycle enable strobe inside the bus clock. Because of this, the block never exchanges values with software directly. Loading the counter, updating a compare register and capturing the count for a read each go through a request/busy handshake. Software watches the progress of each handshake in an access-status register.

The bus side is a plain register port. A write happens on any cycle with the write strobe high. Reads are combinational from the address and have no side effects. There is no stream traffic, so no valid/ready pairs appear. Every pin is plain control or data.

A handshake starts when the bus writes the relevant register. It waits for the next tick strobe and then completes `LAT` cycles later. On completion it applies the staged value or captures the live count, and drops its busy flag. Ticks drive the handshakes whether or not the counter is enabled.

Top module: `tmr_top`

## Requirements
- R1: After reset, every compare register reads all ones. The count, status, interrupt-enable, control and access-status registers read 0, and `irq_o` is 0.
- R2: When control bit 0 is 1, each tick strobe adds one to the counter, modulo 2^W. When control bit 0 is 0, the counter holds its value.
- R3: A control write with bit 1 set starts a snapshot, and access-status bit 5 reads 1 from the next cycle. Bit 5 still reads 1 `LAT` cycles after the first tick strobe that follows the request. It reads 0 one cycle later, and the count register (word 4, byte 0x10) then holds the live count.
- R4: A write to the count register stages a counter load and sets access-status bit 4. The counter takes the staged value when the handshake completes. A further count write while bit 4 is 1 is ignored.
- R5: A write to compare register k (byte offset 4·k) sets access-status bit k. The value reaches the comparator when the handshake completes. A compare write while bit k is 1 is ignored, and the register keeps reading the first value.
- R6: Status bit k (word 5, byte 0x14) is set when an enabled tick makes the counter equal to compare register k. The bit stays set until software clears it.
- R7: A status write clears each bit whose written bit is 1 and leaves bits written 0 unchanged. A hit in the same cycle wins over the clear.
- R8: `irq_o` is 1 exactly when some status bit k and interrupt-enable bit k (word 7, byte 0x1C) are both 1.
- R9: Control (word 8, byte 0x20) reads back the enable in bit 0. Bit 1 always reads 0. Access status is word 9, byte 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe from the counter domain |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address; writes with non-zero low two bits are ignored |
| bus_wdata_i | input | W | Write data |
| bus_rdata_o | output | W | Read data for `bus_addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
Some behaviours are checked on every cycle by the assertions. Among them: the counter never moves without a tick or load, it steps by exactly one when it does, and a load takes the staged value. A handshake never finishes without being busy, and it never turns busy without a request. Staged compare values hold while their handshake is pending, and status flags stay set unless a clear names them. Other behaviours only the bench's scenarios can show: the exact snapshot latency after a tick, the count values and match flags across wrap and boundary windows, the ignored second writes as seen at readback, and how the interrupt follows the masking.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] IDX_CNT = 4'd4;
  localparam logic [WORD_W-1:0] IDX_STS = 4'd5;
  localparam logic [WORD_W-1:0] IDX_IER = 4'd7;
  localparam logic [WORD_W-1:0] IDX_CTL = 4'd8;
  localparam logic [WORD_W-1:0] IDX_ACC = 4'd9;
  localparam int unsigned ACC_CNT_WR = 4;
  localparam int unsigned ACC_CNT_RD = 5;
endpackage

// File: rtl/tmr_handshake.sv
`timescale 1ns/1ps
module tmr_handshake #(
  parameter int unsigned LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic req_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic          busy_q;
  logic          armed_q;
  logic [CW-1:0] wait_q;

  assign done_o = armed_q && (wait_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      wait_q  <= '0;
    end else if (done_o) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!busy_q && req_i) begin
      busy_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (busy_q && !armed_q && tick_i) begin
      armed_q <= 1'b1;
      wait_q  <= CW'(LAT - 1);
    end else if (armed_q) begin
      wait_q  <= wait_q - 1'b1;
    end
  end

  // R3
  done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_q);

  // R3
  busy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(req_i));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int unsigned W    = 32,
  parameter int unsigned NCMP = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      en_i,
  input  logic                      load_i,
  input  logic [W-1:0]              load_val_i,
  input  logic [NCMP-1:0][W-1:0]    match_i,
  output logic [W-1:0]              cnt_o,
  output logic [NCMP-1:0]           hit_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         step;

  assign step    = tick_i && en_i && !load_i;
  assign cnt_nxt = cnt_q + W'(1);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= cnt_nxt;
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign hit_o[k] = step && (cnt_nxt == match_i[k]);
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> (cnt_q == $past(cnt_q)));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en_i && !load_i) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/tmr_top.sv
`timescale 1ns/1ps
module tmr_top
  import tmr_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned NCMP = 4,
  parameter int unsigned LAT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  output logic              irq_o
);
  logic [WORD_W-1:0]     word;
  logic                  aligned;
  logic                  wr_cnt, wr_sts, wr_ier, wr_ctl;
  logic [NCMP-1:0]       wr_match;
  logic [NCMP-1:0]       m_busy, m_done;
  logic [NCMP-1:0][W-1:0] m_stage_q, m_live_q;
  logic [W-1:0]          c_stage_q, snap_q, cnt;
  logic                  c_busy, c_done, s_busy, s_done;
  logic                  en_q;
  logic [NCMP-1:0]       ier_q, sts_q, hit, clr;

  assign word    = bus_addr_i[ADDR_W-1:2];
  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign wr_cnt  = bus_we_i && aligned && (word == IDX_CNT);
  assign wr_sts  = bus_we_i && aligned && (word == IDX_STS);
  assign wr_ier  = bus_we_i && aligned && (word == IDX_IER);
  assign wr_ctl  = bus_we_i && aligned && (word == IDX_CTL);

  for (genvar k = 0; k < NCMP; k++) begin : g_match
    assign wr_match[k] = bus_we_i && aligned && (word == WORD_W'(k));

    tmr_handshake #(.LAT(LAT)) u_hs (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .req_i(wr_match[k] && !m_busy[k]),
      .busy_o(m_busy[k]), .done_o(m_done[k])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m_stage_q[k] <= '1;
        m_live_q[k]  <= '1;
      end else begin
        if (wr_match[k] && !m_busy[k]) m_stage_q[k] <= bus_wdata_i;
        if (m_done[k])                 m_live_q[k]  <= m_stage_q[k];
      end
    end

    // R5
    stage_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_busy[k] |=> (m_stage_q[k] == $past(m_stage_q[k])));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[k] && !clr[k]) |=> sts_q[k]);
  end

  tmr_handshake #(.LAT(LAT)) u_hs_cwr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .req_i(wr_cnt && !c_busy), .busy_o(c_busy), .done_o(c_done)
  );

  tmr_handshake #(.LAT(LAT)) u_hs_snap (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .req_i(wr_ctl && bus_wdata_i[1]), .busy_o(s_busy), .done_o(s_done)
  );

  tmr_counter #(.W(W), .NCMP(NCMP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_q),
    .load_i(c_done), .load_val_i(c_stage_q), .match_i(m_live_q),
    .cnt_o(cnt), .hit_o(hit)
  );

  assign clr = wr_sts ? bus_wdata_i[NCMP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_stage_q <= '0;
      snap_q    <= '0;
      en_q      <= 1'b0;
      ier_q     <= '0;
      sts_q     <= '0;
    end else begin
      if (wr_cnt && !c_busy) c_stage_q <= bus_wdata_i;
      if (s_done)            snap_q    <= cnt;
      if (wr_ctl)            en_q      <= bus_wdata_i[0];
      if (wr_ier)            ier_q     <= bus_wdata_i[NCMP-1:0];
      sts_q <= (sts_q & ~clr) | hit;
    end
  end

  assign irq_o = |(sts_q & ier_q);

  always_comb begin
    bus_rdata_o = '0;
    if (aligned) begin
      for (int k = 0; k < NCMP; k++)
        if (word == WORD_W'(k)) bus_rdata_o = m_stage_q[k];
      case (word)
        IDX_CNT: bus_rdata_o = snap_q;
        IDX_STS: bus_rdata_o[NCMP-1:0] = sts_q;
        IDX_IER: bus_rdata_o[NCMP-1:0] = ier_q;
        IDX_CTL: bus_rdata_o[0] = en_q;
        IDX_ACC: begin
          bus_rdata_o[NCMP-1:0]   = m_busy;
          bus_rdata_o[ACC_CNT_WR] = c_busy;
          bus_rdata_o[ACC_CNT_RD] = s_busy;
        end
        default: ;
      endcase
    end
  end

  // R4
  cstage_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_busy |=> (c_stage_q == $past(c_stage_q)));

  // R3
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_done |=> (snap_q == $past(cnt) && !s_busy));
endmodule

// File: tb/tmr_top_tb.sv
`timescale 1ns/1ps
module tmr_top_tb;
  localparam int unsigned LAT = 2;
  localparam logic [5:0] A_M0 = 6'h00, A_M1 = 6'h04, A_CNT = 6'h10, A_STS = 6'h14,
                         A_IER = 6'h1C, A_CTL = 6'h20, A_ACC = 6'h24;
  localparam int NV = 8;
  // {count load, compare 0 value, enabled ticks}
  localparam logic [71:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0005, 8'd10},
    {32'h0000_0000, 32'h0000_0005, 8'd4},
    {32'h0000_0064, 32'h0000_0065, 8'd1},
    {32'hFFFF_FFFE, 32'h0000_0000, 8'd3},
    {32'hFFFF_FFFE, 32'hFFFF_FFFF, 8'd1},
    {32'h0000_000A, 32'h0000_000A, 8'd20},
    {32'h0000_0007, 32'h0000_0014, 8'd13},
    {32'h0000_0007, 32'h0000_0014, 8'd12}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0, irq;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  tmr_top #(.W(32), .NCMP(4), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0; #1 d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic wait_idle(input logic [31:0] mask);
    logic [31:0] s;
    for (int i = 0; i < 20; i++) begin
      rd(A_ACC, s);
      if ((s & mask) == 0) break;
      pulse();
    end
  endtask

  task automatic snapshot(output logic [31:0] v);
    wr(A_CTL, 32'h2);
    wait_idle(32'h20);
    rd(A_CNT, v);
  endtask

  function automatic logic will_hit(input logic [31:0] ld, input logic [31:0] m, input int n);
    for (int k = 1; k <= n; k++)
      if (ld + 32'(k) == m) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog R1..R9 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_M0, v);  chk("R1 match0", v, 32'hFFFF_FFFF);
    rd(A_M1, v);  chk("R1 match1", v, 32'hFFFF_FFFF);
    rd(A_CNT, v); chk("R1 count", v, 0);
    rd(A_STS, v); chk("R1 status", v, 0);
    rd(A_IER, v); chk("R1 ier", v, 0);
    rd(A_CTL, v); chk("R1 ctrl", v, 0);
    rd(A_ACC, v); chk("R1 access", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R9 control readback, R3 exact snapshot latency
    wr(A_CTL, 32'h3);
    rd(A_CTL, v); chk("R9 ctrl bit1 reads 0", v, 32'h1);
    rd(A_ACC, v); chk("R3 snapshot pending", v & 32'h20, 32'h20);
    pulse();
    repeat (LAT - 2) @(negedge clk);
    rd(A_ACC, v); chk("R3 busy at LAT", v & 32'h20, 32'h20);
    rd(A_ACC, v); chk("R3 clear at LAT+1", v & 32'h20, 0);
    rd(A_CNT, v); chk("R3 snapshot value", v, 32'h1);
    wr(A_CTL, 32'h0);

    // R2 R3 R4 R5 R6 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] ld, m, got;
      int n;
      ld = VEC[i][71:40]; m = VEC[i][39:8]; n = int'(VEC[i][7:0]);
      wr(A_CTL, 32'h0);
      wr(A_CNT, ld);  wait_idle(32'h10);
      wr(A_M0, m);    wait_idle(32'h01);
      wr(A_STS, 32'hF);
      wr(A_CTL, 32'h1);
      for (int t = 0; t < n; t++) pulse();
      wr(A_CTL, 32'h0);
      snapshot(got);
      chk($sformatf("R2 vec%0d count", i), got, ld + 32'(n));
      rd(A_STS, got);
      chk($sformatf("R6 vec%0d flag", i), {31'b0, got[0]}, {31'b0, will_hit(ld, m, n)});
    end

    // R2 hold while disabled
    snapshot(v);
    for (int t = 0; t < 5; t++) pulse();
    begin
      logic [31:0] v2;
      snapshot(v2);
      chk("R2 hold when disabled", v2, v + 32'd0);
    end

    // R5 ignored compare write while pending
    wr(A_M1, 32'h55);
    rd(A_ACC, v); chk("R5 match1 pending", v & 32'h2, 32'h2);
    wr(A_M1, 32'h66);
    wait_idle(32'h02);
    rd(A_M1, v); chk("R5 second write ignored", v, 32'h55);

    // R4 ignored count write while pending
    wr(A_CNT, 32'h1000);
    rd(A_ACC, v); chk("R4 count write pending", v & 32'h10, 32'h10);
    wr(A_CNT, 32'h2000);
    wait_idle(32'h10);
    snapshot(v); chk("R4 load value kept", v, 32'h1000);

    // R6 R7 R8 flags and interrupt
    wr(A_CNT, 32'h54); wait_idle(32'h10);
    wr(A_STS, 32'hF);
    wr(A_CTL, 32'h1);
    pulse();
    wr(A_CTL, 32'h0);
    rd(A_STS, v); chk("R6 match1 flag only", v, 32'h2);
    for (int t = 0; t < 3; t++) pulse();
    rd(A_STS, v); chk("R6 flag sticky", v, 32'h2);
    chk("R8 irq masked", {31'b0, irq}, 0);
    wr(A_IER, 32'h1);
    @(negedge clk); chk("R8 irq other bit", {31'b0, irq}, 0);
    wr(A_IER, 32'h2);
    @(negedge clk); chk("R8 irq raised", {31'b0, irq}, 1);
    wr(A_STS, 32'h1);
    rd(A_STS, v); chk("R7 clear other bit keeps", v, 32'h2);
    wr(A_STS, 32'h2);
    rd(A_STS, v); chk("R7 clear by one", v, 0);
    chk("R8 irq dropped", {31'b0, irq}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule